// File: doc/BRIEF.md
# Display Auxiliary-Channel Transaction Sequencer

This block runs a single auxiliary-channel transaction on behalf of a user against a register-mapped link engine. It acts as a master on a simple register port. It waits until the engine is quiet and claims it with a request/grant handshake. It then confirms that a sink is attached and, for writes, loads a 16-byte write buffer. It builds the control word and programs the address. Each attempt begins with a reset pulse to the engine, then a start, then a poll until the engine finishes. The sequencer reads the reply status and retries on deferral when the user allows it. Whatever the outcome, it hands ownership back before it answers.

A request carries a 4-bit command (bit 0 set means read), a 20-bit address, a byte count of 1 to 16, 16 bytes of write data and a retry flag. The response carries a 3-bit result (0 OK, 1 busy, 2 no device, 3 timeout, 4 I/O error), the 4-bit reply code and up to 16 bytes of read data. All waits count ticks of an internal microsecond divider. `TICK_DIV` sets the clock cycles per tick, `POLL_LIMIT` caps polling, `GAP_TICKS` sets the pause between attempts and `MAX_TRY` caps the attempts.

Register indices on the master port are: 0 address, 1 control, 2 status, 4..7 write buffer words, 8..11 read buffer words. A read strobe expects `reg_rdata` to be valid in the same cycle.

Top module: `aux_txn_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and no register access is made. No register access happens while the block is idle.
- R2: Before claiming the engine, the block reads control once per tick until bit 16 and bits 25:24 are all zero. If `POLL_LIMIT` reads in a row fail the test, the next read ends the transaction with result 1 (busy).
- R3: The block writes control back with bits 21:20 set to 01 and every other bit kept. It then polls once per tick until bits 25:24 read 01, with the same limit as R2 and result 1 on expiry.
- R4: The block then reads status. If bit 28 is clear, the result is 2 (no device) and no attempt is made.
- R5: For a command with bit 0 clear, four words go to indices 4..7 with byte k of the data in bits 8*(k%4)+7:8*(k%4) of word k/4. Bytes at or beyond the count are zero. A read command writes no buffer word.
- R6: The block reads control, clears bits 16, 15:12 and 7:0, and places the command at 15:12 and the count minus one at 7:0. It then writes the address to index 0.
- R7: Each attempt writes control with bit 31 set, then at once without it, then with bit 16 set. It then polls once per tick until bit 16 reads clear. If `POLL_LIMIT` reads in a row fail the test, the next read ends the transaction with result 4.
- R8: The first attempt starts in the cycle after the reset write. Every later attempt waits `GAP_TICKS` ticks between the reset write and the start write.
- R9: A reply field (status bits 19:16) of 8 or 2 counts as a deferral. It triggers another attempt only when the retry flag is set, up to `MAX_TRY` attempts in all. Otherwise the result is 0 with that reply.
- R10: Status bit 8 gives result 3 and any of status bits 11:9 gives result 4. Bits 11:9 win over bit 8. Either one ends the attempts.
- R11: For a read command whose attempts completed, indices 8..11 are read once each. Bytes below the count are returned with the R5 packing and the rest are zero. After a start timeout, `rsp_rdata` is zero.
- R12: On every exit path, the last register access before the response reads control and writes it back with bits 21:20 and 16 cleared.
- R13: A request is taken only when `req_valid` and `req_ready` are both high. The response holds its values until `rsp_ready`, and no request is taken meanwhile.
- R14: Result 0 reports the reply field of the last status read. Any other result reports a reply of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_cmd | input | 4 | Command type, bit 0 set for read |
| req_addr | input | 20 | Transaction address |
| req_len | input | 5 | Byte count, 1 to 16 |
| req_retry | input | 1 | Retry on deferral |
| req_wdata | input | 128 | Write bytes, byte 0 in bits 7:0 |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_result | output | 3 | Result code |
| rsp_reply | output | 4 | Reply code |
| rsp_rdata | output | 128 | Read bytes, byte 0 in bits 7:0 |
| reg_en | output | 1 | Register access strobe |
| reg_we | output | 1 | Access is a write |
| reg_idx | output | 4 | Register index |
| reg_wdata | output | 32 | Register write data |
| reg_rdata | input | 32 | Register read data, same cycle as strobe |

## Verification
The assertions assume that `rsp_ready` never goes high before `rsp_valid` is raised. They also assume that `req_len` lies between 1 and 16 whenever `req_valid` is high. The bench keeps to both: it raises `rsp_ready` only after it has seen the response, and it uses only legal counts. The engine in the bench answers reads in the same cycle as the strobe. It sets the grant field only after a request, and it clears the busy bit only after a scripted number of reads.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;

    // register indices on the master port
    localparam logic [3:0] IDX_ADDR = 4'd0;
    localparam logic [3:0] IDX_CTRL = 4'd1;
    localparam logic [3:0] IDX_STAT = 4'd2;
    localparam logic [3:0] IDX_WBUF = 4'd4;
    localparam logic [3:0] IDX_RBUF = 4'd8;

    // control word fields
    localparam int CTL_RESET_BIT = 31;
    localparam int CTL_START_BIT = 16;
    localparam int CTL_REQ_LSB   = 20;
    localparam int CTL_GNT_LSB   = 24;
    localparam logic [1:0]  OWN_REQ_VAL  = 2'b01;
    localparam logic [1:0]  OWN_GNT_VAL  = 2'b01;
    localparam logic [31:0] CTL_CMD_CLR  = 32'h0001_F0FF;
    localparam logic [31:0] CTL_REL_CLR  = 32'h0031_0000;

    // status word fields
    localparam int STS_SINK_BIT  = 28;
    localparam int STS_REPLY_LSB = 16;
    localparam int STS_TMO_BIT   = 8;
    localparam int STS_ERR_LSB   = 9;

    typedef enum logic [2:0] {
        RES_OK      = 3'd0,
        RES_BUSY    = 3'd1,
        RES_NODEV   = 3'd2,
        RES_TIMEOUT = 3'd3,
        RES_IOERR   = 3'd4
    } aux_res_e;

    typedef enum logic [4:0] {
        S_IDLE, S_CHK_RD, S_CHK_WT, S_REQ_WR, S_GNT_RD, S_GNT_WT,
        S_SINK_RD, S_WBUF_WR, S_CTL_RD, S_ADDR_WR, S_RST_HI, S_RST_LO,
        S_GAP, S_START_WR, S_BSY_RD, S_BSY_WT, S_STAT_RD, S_RBUF_RD,
        S_REL_RD, S_REL_WR, S_RSP
    } aux_state_e;

endpackage

// File: rtl/aux_us_tick.sv
module aux_us_tick #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == CW'(DIV - 1));
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/aux_byte_keep.sv
module aux_byte_keep #(
    parameter int NB = 16
) (
    input  logic [8*NB-1:0]          data_i,
    input  logic [$clog2(NB+1)-1:0]  len_i,
    output logic [8*NB-1:0]          data_o
);
    localparam int LW = $clog2(NB + 1);

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign data_o[8*b +: 8] = (LW'(b) < len_i) ? data_i[8*b +: 8] : 8'h00;
    end
endmodule

// File: rtl/aux_reply_class.sv
module aux_reply_class (
    input  logic [3:0] reply_i,
    input  logic       tmo_i,
    input  logic [2:0] err_i,
    output logic       defer_o,
    output logic       tmo_o,
    output logic       ioerr_o
);
    always_comb begin
        defer_o = (reply_i == 4'h8) || (reply_i == 4'h2);
        ioerr_o = |err_i;
        tmo_o   = tmo_i && !ioerr_o;
    end
endmodule

// File: rtl/aux_txn_seq.sv
module aux_txn_seq
    import aux_seq_pkg::*;
#(
    parameter int TICK_DIV   = 100,
    parameter int POLL_LIMIT = 1000,
    parameter int GAP_TICKS  = 400,
    parameter int MAX_TRY    = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    output logic         req_ready,
    input  logic [3:0]   req_cmd,
    input  logic [19:0]  req_addr,
    input  logic [4:0]   req_len,
    input  logic         req_retry,
    input  logic [127:0] req_wdata,
    output logic         rsp_valid,
    input  logic         rsp_ready,
    output logic [2:0]   rsp_result,
    output logic [3:0]   rsp_reply,
    output logic [127:0] rsp_rdata,
    output logic         reg_en,
    output logic         reg_we,
    output logic [3:0]   reg_idx,
    output logic [31:0]  reg_wdata,
    input  logic [31:0]  reg_rdata
);
    localparam int NBYTES = 16;
    localparam int PCW    = $clog2(POLL_LIMIT + 1);
    localparam int GCW    = $clog2(GAP_TICKS + 1);
    localparam int TCW    = $clog2(MAX_TRY + 1);

    typedef struct packed {
        aux_state_e   state;
        logic [3:0]   cmd;
        logic [19:0]  addr;
        logic [4:0]   len;
        logic         retry;
        logic [127:0] wdata;
        logic [127:0] rdata;
        logic [31:0]  rd;
        logic [31:0]  ctl;
        logic [PCW-1:0] poll_cnt;
        logic [GCW-1:0] gap_cnt;
        logic [TCW-1:0] try_cnt;
        logic [1:0]   word;
        aux_res_e     res;
        logic [3:0]   reply;
    } seq_t;

    seq_t d, q;
    logic tick;
    logic [127:0] wdata_kept, rdata_kept;
    logic st_defer, st_tmo, st_ioerr;

    aux_us_tick #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

    aux_byte_keep #(.NB(NBYTES)) u_wkeep (
        .data_i(req_wdata), .len_i(req_len), .data_o(wdata_kept));

    aux_byte_keep #(.NB(NBYTES)) u_rkeep (
        .data_i(q.rdata), .len_i(q.len), .data_o(rdata_kept));

    aux_reply_class u_class (
        .reply_i(reg_rdata[STS_REPLY_LSB +: 4]),
        .tmo_i  (reg_rdata[STS_TMO_BIT]),
        .err_i  (reg_rdata[STS_ERR_LSB +: 3]),
        .defer_o(st_defer),
        .tmo_o  (st_tmo),
        .ioerr_o(st_ioerr));

    always_comb begin
        d         = q;
        reg_en    = 1'b0;
        reg_we    = 1'b0;
        reg_idx   = IDX_CTRL;
        reg_wdata = '0;
        unique case (q.state)
            S_IDLE: if (req_valid) begin
                d.cmd      = req_cmd;
                d.addr     = req_addr;
                d.len      = req_len;
                d.retry    = req_retry;
                d.wdata    = wdata_kept;
                d.rdata    = '0;
                d.res      = RES_OK;
                d.reply    = '0;
                d.poll_cnt = '0;
                d.try_cnt  = '0;
                d.state    = S_CHK_RD;
            end
            S_CHK_RD: begin
                reg_en  = 1'b1;
                d.rd    = reg_rdata;
                d.state = S_CHK_WT;
            end
            S_CHK_WT: if (tick) begin
                if (q.poll_cnt == PCW'(POLL_LIMIT)) begin
                    d.res   = RES_BUSY;
                    d.state = S_REL_RD;
                end else if (!q.rd[CTL_START_BIT] && q.rd[CTL_GNT_LSB +: 2] == 2'b00) begin
                    d.poll_cnt = '0;
                    d.state    = S_REQ_WR;
                end else begin
                    d.poll_cnt = q.poll_cnt + 1'b1;
                    d.state    = S_CHK_RD;
                end
            end
            S_REQ_WR: begin
                reg_en    = 1'b1;
                reg_we    = 1'b1;
                reg_wdata = q.rd;
                reg_wdata[CTL_REQ_LSB +: 2] = OWN_REQ_VAL;
                d.state   = S_GNT_RD;
            end
            S_GNT_RD: begin
                reg_en  = 1'b1;
                d.rd    = reg_rdata;
                d.state = S_GNT_WT;
            end
            S_GNT_WT: if (tick) begin
                if (q.poll_cnt == PCW'(POLL_LIMIT)) begin
                    d.res   = RES_BUSY;
                    d.state = S_REL_RD;
                end else if (q.rd[CTL_GNT_LSB +: 2] == OWN_GNT_VAL) begin
                    d.state = S_SINK_RD;
                end else begin
                    d.poll_cnt = q.poll_cnt + 1'b1;
                    d.state    = S_GNT_RD;
                end
            end
            S_SINK_RD: begin
                reg_en  = 1'b1;
                reg_idx = IDX_STAT;
                d.word  = '0;
                if (!reg_rdata[STS_SINK_BIT]) begin
                    d.res   = RES_NODEV;
                    d.state = S_REL_RD;
                end else if (!q.cmd[0]) begin
                    d.state = S_WBUF_WR;
                end else begin
                    d.state = S_CTL_RD;
                end
            end
            S_WBUF_WR: begin
                reg_en    = 1'b1;
                reg_we    = 1'b1;
                reg_idx   = IDX_WBUF + {2'b00, q.word};
                reg_wdata = q.wdata[32*q.word +: 32];
                d.word    = q.word + 1'b1;
                if (q.word == 2'd3) d.state = S_CTL_RD;
            end
            S_CTL_RD: begin
                reg_en  = 1'b1;
                d.ctl   = (reg_rdata & ~CTL_CMD_CLR)
                        | {16'h0000, q.cmd, 4'h0, 3'b000, 5'(q.len - 5'd1)};
                d.state = S_ADDR_WR;
            end
            S_ADDR_WR: begin
                reg_en    = 1'b1;
                reg_we    = 1'b1;
                reg_idx   = IDX_ADDR;
                reg_wdata = {12'h000, q.addr};
                d.state   = S_RST_HI;
            end
            S_RST_HI: begin
                reg_en    = 1'b1;
                reg_we    = 1'b1;
                reg_wdata = q.ctl;
                reg_wdata[CTL_RESET_BIT] = 1'b1;
                d.state   = S_RST_LO;
            end
            S_RST_LO: begin
                reg_en    = 1'b1;
                reg_we    = 1'b1;
                reg_wdata = q.ctl;
                d.gap_cnt = '0;
                d.state   = (q.try_cnt != '0) ? S_GAP : S_START_WR;
            end
            S_GAP: if (tick) begin
                if (q.gap_cnt == GCW'(GAP_TICKS - 1)) d.state = S_START_WR;
                else d.gap_cnt = q.gap_cnt + 1'b1;
            end
            S_START_WR: begin
                reg_en     = 1'b1;
                reg_we     = 1'b1;
                reg_wdata  = q.ctl;
                reg_wdata[CTL_START_BIT] = 1'b1;
                d.poll_cnt = '0;
                d.state    = S_BSY_RD;
            end
            S_BSY_RD: begin
                reg_en  = 1'b1;
                d.rd    = reg_rdata;
                d.state = S_BSY_WT;
            end
            S_BSY_WT: if (tick) begin
                if (q.poll_cnt == PCW'(POLL_LIMIT)) begin
                    d.res   = RES_IOERR;
                    d.state = S_REL_RD;
                end else if (!q.rd[CTL_START_BIT]) begin
                    d.state = S_STAT_RD;
                end else begin
                    d.poll_cnt = q.poll_cnt + 1'b1;
                    d.state    = S_BSY_RD;
                end
            end
            S_STAT_RD: begin
                reg_en  = 1'b1;
                reg_idx = IDX_STAT;
                d.reply = reg_rdata[STS_REPLY_LSB +: 4];
                d.word  = '0;
                if (st_ioerr)    d.res = RES_IOERR;
                else if (st_tmo) d.res = RES_TIMEOUT;
                if (!st_ioerr && !st_tmo && st_defer && q.retry
                    && q.try_cnt != TCW'(MAX_TRY - 1)) begin
                    d.try_cnt = q.try_cnt + 1'b1;
                    d.state   = S_RST_HI;
                end else if (q.cmd[0]) begin
                    d.state = S_RBUF_RD;
                end else begin
                    d.state = S_REL_RD;
                end
            end
            S_RBUF_RD: begin
                reg_en  = 1'b1;
                reg_idx = IDX_RBUF + {2'b00, q.word};
                d.rdata[32*q.word +: 32] = reg_rdata;
                d.word  = q.word + 1'b1;
                if (q.word == 2'd3) d.state = S_REL_RD;
            end
            S_REL_RD: begin
                reg_en  = 1'b1;
                d.rd    = reg_rdata;
                d.state = S_REL_WR;
            end
            S_REL_WR: begin
                reg_en    = 1'b1;
                reg_we    = 1'b1;
                reg_wdata = q.rd & ~CTL_REL_CLR;
                d.state   = S_RSP;
            end
            S_RSP: if (rsp_ready) d.state = S_IDLE;
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= S_IDLE;
            q.res   <= RES_OK;
        end else begin
            q <= d;
        end
    end

    assign req_ready  = (q.state == S_IDLE);
    assign rsp_valid  = (q.state == S_RSP);
    assign rsp_result = q.res;
    assign rsp_reply  = (q.res == RES_OK) ? q.reply : 4'h0;
    assign rsp_rdata  = rdata_kept;

endmodule

// File: rtl/aux_seq_checker.sv
module aux_seq_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         req_ready,
    input logic         rsp_valid,
    input logic         rsp_ready,
    input logic [2:0]   rsp_result,
    input logic [3:0]   rsp_reply,
    input logic [127:0] rsp_rdata,
    input logic         reg_en,
    input logic         reg_we,
    input logic [3:0]   reg_idx,
    input logic [31:0]  reg_wdata
);
    logic ctrl_wr;
    assign ctrl_wr = reg_en && reg_we && (reg_idx == 4'd1);

    p_rsp_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_result)
                                    && $stable(rsp_reply) && $stable(rsp_rdata));

    p_no_accept_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    p_reset_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && reg_wdata[31] |=> ctrl_wr && !reg_wdata[31] && !reg_wdata[16]);

    p_start_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && reg_wdata[16] |-> !reg_wdata[31]);

    p_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> $past(ctrl_wr && reg_wdata[21:20] == 2'b00 && !reg_wdata[16]));

    p_err_reply_r14: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_result != 3'd0 |-> rsp_reply == 4'h0);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !reg_en);
endmodule

bind aux_txn_seq aux_seq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_result(rsp_result), .rsp_reply(rsp_reply),
    .rsp_rdata(rsp_rdata), .reg_en(reg_en), .reg_we(reg_we),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata));

// File: tb/aux_txn_seq_test.sv
`timescale 1ns/1ps
module aux_txn_seq_test;
    localparam int D = 4, P = 8, G = 5;
    localparam logic [31:0] CTRL_INIT = 32'h0800_A0F3;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_retry = 0, rsp_ready = 0;
    logic [3:0] req_cmd = 0;
    logic [19:0] req_addr = 0;
    logic [4:0] req_len = 1;
    logic [127:0] req_wdata = 0;
    logic req_ready, rsp_valid, reg_en, reg_we;
    logic [2:0] rsp_result;
    logic [3:0] rsp_reply, reg_idx;
    logic [127:0] rsp_rdata;
    logic [31:0] reg_wdata, reg_rdata = 0;

    always #2.5 clk = ~clk;

    aux_txn_seq #(.TICK_DIV(D), .POLL_LIMIT(P), .GAP_TICKS(G), .MAX_TRY(32)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len),
        .req_retry(req_retry), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_result(rsp_result), .rsp_reply(rsp_reply),
        .rsp_rdata(rsp_rdata), .reg_en(reg_en), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

    int checks = 0, errors = 0;

    // engine script
    int ib, gw, sb, sink;
    int rep_a[40], err_a[40];
    logic [31:0] rbuf[4];
    // engine state and logs
    logic [31:0] ctrl_reg, last_ctrl_rd, last_ctrl_w, addr_w, ctl_lo;
    logic [31:0] wbuf_log[4];
    int wbuf_cnt, rbuf_cnt, starts, start_busy, granted, cyc, t_lo, first_gap, min_gap;
    bit prev_hi;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] keep(input logic [127:0] v, input int n);
        logic [127:0] r = '0;
        for (int b = 0; b < n; b++) r[8*b +: 8] = v[8*b +: 8];
        return r;
    endfunction

    // behavioural engine and per-cycle protocol check
    always @(negedge clk) begin
        logic [31:0] v;
        cyc++;
        reg_rdata = '0;
        if (rst_n) begin
            checks++;
            if ((req_ready && reg_en) || (reg_we && !reg_en)) begin
                errors++;
                $display("FAIL R1: idle access en=%b we=%b ready=%b expected no access", reg_en, reg_we, req_ready);
            end
        end
        if (reg_en && !reg_we) begin
            if (reg_idx == 4'd1) begin
                v = ctrl_reg & ~32'h0301_0000;
                if (ctrl_reg[21:20] == 2'b00) begin
                    if (ib > 0) begin ib--; v[16] = 1'b1; end
                end else begin
                    if (!granted) begin
                        if (gw > 0) gw--; else granted = 1;
                    end
                    if (granted) v[24] = 1'b1;
                end
                if (start_busy > 0) begin start_busy--; v[16] = 1'b1; end
                last_ctrl_rd = v;
                reg_rdata = v;
            end else if (reg_idx == 4'd2) begin
                v = sink[0] ? 32'h1000_0000 : 32'h0;
                if (starts > 0) v = v | (32'(rep_a[starts-1]) << 16) | 32'(err_a[starts-1]);
                reg_rdata = v;
            end else if (reg_idx >= 4'd8 && reg_idx <= 4'd11) begin
                rbuf_cnt++;
                reg_rdata = rbuf[reg_idx - 4'd8];
            end
        end
        if (reg_en && reg_we) begin
            if (reg_idx == 4'd0) addr_w = reg_wdata;
            else if (reg_idx >= 4'd4 && reg_idx <= 4'd7) begin
                wbuf_log[reg_idx - 4'd4] = reg_wdata;
                wbuf_cnt++;
            end else if (reg_idx == 4'd1) begin
                if (prev_hi && !reg_wdata[31]) begin t_lo = cyc; ctl_lo = reg_wdata; end
                if (reg_wdata[16]) begin
                    starts++;
                    start_busy = sb;
                    if (starts == 1) first_gap = cyc - t_lo;
                    else if (cyc - t_lo < min_gap) min_gap = cyc - t_lo;
                end
                ctrl_reg = reg_wdata;
                if (reg_wdata[21:20] == 2'b00) granted = 0;
                last_ctrl_w = reg_wdata;
            end
        end
        prev_hi = reg_en && reg_we && reg_idx == 4'd1 && reg_wdata[31];
    end

    task automatic setup(input int i_ib, input int i_gw, input int i_sb, input int i_sink);
        ib = i_ib; gw = i_gw; sb = i_sb; sink = i_sink;
        for (int k = 0; k < 40; k++) begin rep_a[k] = 0; err_a[k] = 0; end
    endtask

    task automatic run(input logic [3:0] cmd, input int len, input logic [19:0] addr,
                       input bit retry, input logic [127:0] wd, input int dly);
        int e_att, e_res, e_rep, c_ib, c_gw, wait_n;
        bit rb;
        logic [127:0] e_rd, exp_w;
        logic [31:0] e_ctl;
        logic [2:0] s_res; logic [3:0] s_rep; logic [127:0] s_rd;
        c_ib = ib; c_gw = gw;
        // expected outcome from the requirements
        e_att = 0; e_res = 0; e_rep = 0; rb = 0;
        if (c_ib >= P) e_res = 1;
        else if (c_gw >= P) e_res = 1;
        else if (!sink) e_res = 2;
        else begin
            for (int a = 0; a < 32; a++) begin
                e_att = a + 1;
                if (sb >= P) begin e_res = 4; rb = 0; break; end
                e_rep = rep_a[a]; rb = 1;
                if (err_a[a] & 'hE00) e_res = 4;
                else if (err_a[a] & 'h100) e_res = 3;
                if (e_res != 0) break;
                if (!((e_rep == 8 || e_rep == 2) && retry)) break;
            end
        end
        if (e_res != 0) e_rep = 0;
        e_rd = (cmd[0] && rb) ? keep({rbuf[3], rbuf[2], rbuf[1], rbuf[0]}, len) : '0;
        e_ctl = ((CTRL_INIT | 32'h0110_0000) & ~32'h0001_F0FF) | (32'(cmd) << 12) | 32'(len - 1);
        // clear logs
        ctrl_reg = CTRL_INIT; granted = 0; start_busy = 0; starts = 0;
        wbuf_cnt = 0; rbuf_cnt = 0; addr_w = 0; ctl_lo = 0;
        first_gap = -1; min_gap = 1000000;
        for (int k = 0; k < 4; k++) wbuf_log[k] = 0;
        @(negedge clk);
        req_cmd = cmd; req_len = 5'(len); req_addr = addr; req_retry = retry;
        req_wdata = wd; req_valid = 1;
        @(negedge clk);
        req_valid = 0; req_wdata = '1;
        wait_n = 0;
        while (!rsp_valid && wait_n < 20000) begin @(negedge clk); wait_n++; end
        if (!rsp_valid) begin
            checks++; errors++;
            $display("FAIL R13: watchdog, no response actual 0 expected 1");
            return;
        end
        s_res = rsp_result; s_rep = rsp_reply; s_rd = rsp_rdata;
        for (int k = 0; k < dly; k++) begin
            @(negedge clk);
            chk("R13 held", {rsp_valid, rsp_result, rsp_reply, rsp_rdata[31:0]},
                {1'b1, s_res, s_rep, s_rd[31:0]});
        end
        chk("R13 not ready while busy", req_ready, 1'b0);
        rsp_ready = 1;
        @(negedge clk);
        rsp_ready = 0;
        chk("R13 back to idle", req_ready, 1'b1);
        chk("R14 result", s_res, e_res);
        chk("R14 reply", s_rep, e_rep);
        chk("R11 read data", s_rd, e_rd);
        chk("R9 attempts", starts, e_att);
        chk("R12 release", last_ctrl_w, last_ctrl_rd & ~32'h0031_0000);
        if (cmd[0] && rb) chk("R11 rbuf reads", rbuf_cnt, 4);
        else chk("R11 no rbuf reads", rbuf_cnt, 0);
        if (e_att > 0) begin
            chk("R6 control word", ctl_lo, e_ctl);
            chk("R6 address", addr_w, {12'h0, addr});
            chk("R8 first start at once", first_gap, 1);
            if (e_att > 1) begin
                checks++;
                if (min_gap <= (G - 1) * D || min_gap > G * D + 2) begin
                    errors++;
                    $display("FAIL R8: gap actual %0d expected %0d..%0d", min_gap, (G-1)*D+1, G*D+2);
                end
            end
            if (!cmd[0]) begin
                exp_w = keep(wd, len);
                chk("R5 wbuf count", wbuf_cnt, 4);
                chk("R5 wbuf words", {wbuf_log[3], wbuf_log[2], wbuf_log[1], wbuf_log[0]}, exp_w);
            end else chk("R5 no wbuf on read", wbuf_cnt, 0);
        end
    endtask

    initial begin
        #1000000;
        errors++; checks++;
        $display("FAIL watchdog: run hung, actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rbuf[0] = 32'h4433_2211; rbuf[1] = 32'h8877_6655;
        rbuf[2] = 32'hCCBB_AA99; rbuf[3] = 32'h00FF_EEDD;
        setup(0, 0, 0, 1);
        ctrl_reg = CTRL_INIT;
        repeat (3) @(negedge clk);
        chk("R1 reset ready", req_ready, 1'b1);
        chk("R1 reset rsp_valid", rsp_valid, 1'b0);
        chk("R1 reset reg_en", reg_en, 1'b0);
        rst_n = 1;
        // R5 R6 write, no waiting
        setup(0, 0, 0, 1);
        run(4'h0, 5, 20'h12345, 0, 128'h0F0E0D0C_0B0A0908_07060504_03020100, 0);
        // R2 R3 R7 R11 read with busy polls
        setup(3, 2, 2, 1);
        run(4'h1, 3, 20'h00ABC, 0, '0, 0);
        // R4 no sink
        setup(0, 0, 0, 0);
        run(4'h1, 4, 20'h1, 0, '0, 0);
        // R2 boundary: one below the limit passes, at the limit fails
        setup(P - 1, 0, 0, 1);
        run(4'h0, 16, 20'hFFFFF, 0, {4{32'hDEADBEEF}}, 0);
        setup(P, 0, 0, 1);
        run(4'h0, 2, 20'h2, 0, '0, 0);
        // R3 grant never arrives
        setup(0, 100, 0, 1);
        run(4'h1, 2, 20'h3, 0, '0, 0);
        // R7 start never clears
        setup(0, 0, 100, 1);
        run(4'h1, 8, 20'h4, 1, '0, 0);
        // R8 R9 two deferrals then ack
        setup(0, 0, 1, 1);
        rep_a[0] = 8; rep_a[1] = 2; rep_a[2] = 0;
        run(4'h5, 6, 20'h55, 1, 128'h1111_2222_3333_4444_5555_6666, 0);
        // R9 deferral without retry
        setup(0, 0, 0, 1);
        rep_a[0] = 8;
        run(4'h1, 4, 20'h66, 0, '0, 0);
        // R9 every attempt defers
        setup(0, 0, 0, 1);
        for (int k = 0; k < 40; k++) rep_a[k] = 2;
        run(4'h1, 16, 20'h77, 1, '0, 0);
        // R10 timeout bit, then I/O error winning over timeout
        setup(0, 0, 0, 1);
        err_a[0] = 'h100;
        run(4'h0, 1, 20'h88, 1, 128'hAB, 0);
        setup(0, 0, 0, 1);
        rep_a[0] = 8; err_a[0] = 'h500;
        run(4'h1, 4, 20'h99, 1, '0, 0);
        // R11 R13 full read with held response
        setup(0, 0, 0, 1);
        rep_a[0] = 1;
        run(4'h1, 16, 20'hAAAAA, 0, '0, 5);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule